// File: doc/BRIEF.md
# Framed Serial Control Word Receiver

This block takes 16-bit control words from a single serial data line. The line is sampled once per falling edge of a separate word clock. Both the word clock and the data line are asynchronous to the system clock. Each is brought in through a synchronizer of the same depth, so each data sample stays aligned with the word-clock edge that qualifies it. A frame opens with a low start bit, followed by fifteen data bits, most significant first. A frame is only accepted once a run of high stop bits has been seen after it. At that point the whole word, with the start bit in the top position, is presented with a one-cycle valid strobe.

A frame can be cut short: a low sample arrives before the required run of stop bits is complete. In that case the pending word is dropped, a one-cycle frame-error strobe is raised, and the low sample is taken as the start bit of the next frame. After reset, the receiver first waits for a full run of high samples before it will recognise a start bit.

The output is a stream with valid only and no ready. The serial source cannot be paused, so there is no back-pressure. The consumer must take the word in the cycle `word_valid` is high. `word_out` keeps the last accepted word until the next one replaces it.

Top module: `scw_rx`

## Requirements
- R1: Data is taken only at a falling edge of `word_clk`. Changes on `ser_data` while `word_clk` is low, after the edge, do not change the received word.
- R2: A frame is a low start bit followed by bits 14 down to 0, in that order. The accepted word has the start bit at bit 15, so `word_out[15]` is 0 whenever `word_valid` is high, and bits 14..0 equal the transmitted data bits.
- R3: `word_valid` rises only after the 16th consecutive high stop bit that follows the last data bit. It rises before the next falling edge of `word_clk`.
- R4: Stop runs longer than 16 bits are accepted. Only one `word_valid` pulse is produced per frame, and the next frame after a long idle is received normally.
- R5: A low sample after the data bits, with fewer than 16 stop bits counted, discards the pending word and pulses `frame_err`. This applies for 0 through 15 stop bits. The low sample starts a new frame, which is then received normally.
- R6: After reset, a start bit is recognised only after 16 consecutive high samples. Lows before that produce neither `word_valid` nor `frame_err`.
- R7: `word_out` changes only in a cycle where `word_valid` is high. It keeps the last accepted word through frame errors and idle time.
- R8: A synchronous active-low `rst_n` clears `word_out` to 0 and drops `word_valid` and `frame_err` by the next clock edge. A frame in progress is abandoned.
- R9: `word_valid` and `frame_err` are each single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_clk | input | 1 | Asynchronous word clock; data is taken at its falling edge |
| ser_data | input | 1 | Asynchronous serial data line, idle high |
| word_out | output | 16 | Last accepted control word, start bit at bit 15 |
| word_valid | output | 1 | One-cycle strobe: `word_out` holds a newly accepted word |
| frame_err | output | 1 | One-cycle strobe: pending frame dropped for a short stop run |

## Verification
Several words are sent back to back, each followed by exactly sixteen stop bits. The words are all zeros, all ones with the top bit set, alternating patterns and an irregular value. Together they show that bit order and start-bit placement are correct, and that no bit is stuck or swapped. Further frames end with 0, 7 and 15 stop bits before the next start. These separate correct abort handling from an off-by-one in the stop count. A 40-bit idle run shows that extra stop bits do not produce extra words. Low frames sent right after reset, both at start-up and in the middle of a frame, show that the arming run is enforced. Noise is placed on the data line during every low phase of the word clock, which shows that only the falling edge samples the line.

// File: rtl/scw_pkg.sv
package scw_pkg;
  typedef enum logic [1:0] {
    ST_HUNT,  // after reset: waiting for a full high run before arming
    ST_IDLE,  // armed: next low sample is a start bit
    ST_DATA,  // shifting in data bits
    ST_STOP   // counting stop bits before commit
  } scw_state_e;
endpackage

// File: rtl/scw_sync.sv
module scw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wclk_in,
  input  logic din_in,
  output logic fall,
  output logic samp_bit
);
  logic [STAGES-1:0] wc_q;
  logic [STAGES-1:0] d_q;
  logic              wc_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            wc_q[0] <= 1'b0;
            d_q[0]  <= 1'b1;
          end else begin
            wc_q[0] <= wclk_in;
            d_q[0]  <= din_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            wc_q[g] <= 1'b0;
            d_q[g]  <= 1'b1;
          end else begin
            wc_q[g] <= wc_q[g-1];
            d_q[g]  <= d_q[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) wc_prev <= 1'b0;
    else        wc_prev <= wc_q[STAGES-1];
  end

  assign fall     = wc_prev & ~wc_q[STAGES-1];
  assign samp_bit = d_q[STAGES-1];
endmodule

// File: rtl/scw_shifter.sv
module scw_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)     word <= '0;
    else if (load)  word <= WORD_W'(bit_in);
    else if (shift) word <= {word[WORD_W-2:0], bit_in};
  end
endmodule

// File: rtl/scw_framer.sv
module scw_framer
  import scw_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int STOP_MIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp,
  input  logic samp_bit,
  output logic start_o,
  output logic shift_o,
  output logic commit_o,
  output logic err_o
);
  localparam int BW = $clog2(WORD_W);
  localparam int SW = $clog2(STOP_MIN + 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_W - 1);
  localparam logic [SW-1:0] LAST_STOP = SW'(STOP_MIN - 1);

  scw_state_e    state;
  logic [BW-1:0] bit_cnt;
  logic [SW-1:0] stop_cnt;

  always_comb begin
    start_o  = 1'b0;
    shift_o  = 1'b0;
    commit_o = 1'b0;
    err_o    = 1'b0;
    case (state)
      ST_IDLE: start_o = samp & ~samp_bit;
      ST_DATA: shift_o = samp;
      ST_STOP: begin
        commit_o = samp & samp_bit & (stop_cnt == LAST_STOP);
        err_o    = samp & ~samp_bit;
        start_o  = samp & ~samp_bit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      bit_cnt  <= '0;
      stop_cnt <= '0;
    end else if (samp) begin
      case (state)
        ST_HUNT: begin
          if (!samp_bit)                   stop_cnt <= '0;
          else if (stop_cnt == LAST_STOP) begin
            stop_cnt <= '0;
            state    <= ST_IDLE;
          end else                         stop_cnt <= stop_cnt + 1'b1;
        end
        ST_IDLE: begin
          if (!samp_bit) begin
            bit_cnt <= BW'(1);
            state   <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (bit_cnt == LAST_BIT) begin
            stop_cnt <= '0;
            state    <= ST_STOP;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (!samp_bit) begin
            bit_cnt <= BW'(1);
            state   <= ST_DATA;
          end else if (stop_cnt == LAST_STOP) begin
            stop_cnt <= '0;
            state    <= ST_IDLE;
          end else begin
            stop_cnt <= stop_cnt + 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/scw_rx.sv
module scw_rx #(
  parameter int WORD_W      = 16,
  parameter int STOP_MIN    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_clk,
  input  logic              ser_data,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              frame_err
);
  logic              samp;
  logic              samp_bit;
  logic              start;
  logic              shift;
  logic              commit;
  logic              err;
  logic [WORD_W-1:0] shreg;

  scw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .wclk_in  (word_clk),
    .din_in   (ser_data),
    .fall     (samp),
    .samp_bit (samp_bit)
  );

  scw_framer #(.WORD_W(WORD_W), .STOP_MIN(STOP_MIN)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .samp     (samp),
    .samp_bit (samp_bit),
    .start_o  (start),
    .shift_o  (shift),
    .commit_o (commit),
    .err_o    (err)
  );

  scw_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .shift  (shift),
    .bit_in (samp_bit),
    .word   (shreg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_out   <= '0;
      word_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      word_valid <= commit;
      frame_err  <= err;
      if (commit) word_out <= shreg;
    end
  end
endmodule

// File: rtl/scw_rx_chk.sv
module scw_rx_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_out,
  input logic              word_valid,
  input logic              frame_err
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && frame_err));

  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !word_out[WORD_W-1]);

  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !word_valid) |-> $stable(word_out));

  p_reset_clears_r8: assert property (@(posedge clk)
    !rst_n |=> (!word_valid && !frame_err && word_out == '0));
endmodule

bind scw_rx scw_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_out   (word_out),
  .word_valid (word_valid),
  .frame_err  (frame_err)
);

// File: tb/scw_rx_tb.sv
module scw_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wck = 1'b1;
  logic        sdat = 1'b1;
  logic [15:0] word_out;
  logic        word_valid;
  logic        frame_err;

  int          total = 0;
  int          bad = 0;
  logic [15:0] exp_q[$];
  int          exp_err = 0;
  int          stop_sent = 0;
  int          valid_seen = 0;
  int          err_seen = 0;
  logic        pv = 1'b0;
  logic        pe = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  scw_rx u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_clk   (wck),
    .ser_data   (sdat),
    .word_out   (word_out),
    .word_valid (word_valid),
    .frame_err  (frame_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit: set up during high phase, fall, then noise in low phase (R1)
  task automatic send_bit(input logic b, input bit is_stop);
    sdat = b;
    tick(6);
    wck = 1'b0;
    if (is_stop) stop_sent++;
    else         stop_sent = 0;
    tick(3);
    sdat = ~b;
    tick(3);
    wck = 1'b1;
  endtask

  task automatic send_tail(input logic [15:0] w, input int nstop);
    for (int i = 14; i >= 0; i--) send_bit(w[i], 1'b0);
    for (int i = 0; i < nstop; i++) send_bit(1'b1, 1'b1);
  endtask

  task automatic send_frame(input logic [15:0] w, input int nstop);
    send_bit(1'b0, 1'b0);
    send_tail(w, nstop);
  endtask

  task automatic expect_word(input logic [15:0] w);
    exp_q.push_back({1'b0, w[14:0]});
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid) begin
        valid_seen++;
        check(!pv, "R9", "valid wider than one cycle", 32'(pv), 0);
        check(!frame_err, "R9", "valid and error together", 32'(frame_err), 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected word", 32'(word_out), 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(word_out == e, "R2", "received word", 32'(word_out), 32'(e));
          check(stop_sent == 16, "R3", "stop bits at commit", 32'(stop_sent), 16);
        end
      end
      if (frame_err) begin
        err_seen++;
        check(!pe, "R9", "error wider than one cycle", 32'(pe), 0);
        check(exp_err > 0, "R5", "unexpected frame error", 1, 0);
        if (exp_err > 0) exp_err--;
      end
    end
    pv = word_valid;
    pe = frame_err;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check(word_out == 16'h0, "R8", "reset word", 32'(word_out), 0);
    check(!word_valid && !frame_err, "R8", "reset strobes",
          32'({word_valid, frame_err}), 0);

    // R6: frame before the arming run is ignored
    repeat (3) send_bit(1'b1, 1'b1);
    send_frame(16'h1234, 16);
    tick(2);
    check(valid_seen == 0 && err_seen == 0, "R6", "no output before arming",
          32'(valid_seen + err_seen), 0);

    // R2/R3: main patterns with exactly 16 stop bits
    expect_word(16'h1234); send_frame(16'h1234, 16);
    expect_word(16'h0000); send_frame(16'h0000, 16);
    expect_word(16'hFFFF); send_frame(16'hFFFF, 16);
    expect_word(16'h5A5A); send_frame(16'h5A5A, 16);
    expect_word(16'h2C3B); send_frame(16'h2C3B, 16);
    tick(2);
    check(valid_seen == 5, "R3", "words after exact stop runs", 32'(valid_seen), 5);

    // R4: long idle
    expect_word(16'h0F0F); send_frame(16'h0F0F, 40);
    expect_word(16'h3003); send_frame(16'h3003, 16);
    tick(2);
    check(valid_seen == 7, "R4", "one word per long-idle frame", 32'(valid_seen), 7);

    // R5/R7: abort after 7 stops; low is start of next frame
    send_frame(16'h1111, 7);
    exp_err++;
    send_bit(1'b0, 1'b0);
    check(err_seen == 1, "R5", "error after 7 stops", 32'(err_seen), 1);
    check(word_out == 16'h3003, "R7", "word held over error", 32'(word_out), 32'h3003);
    expect_word(16'h2222);
    send_tail(16'h2222, 16);

    // R5 boundaries: 15 and 0 stop bits
    send_frame(16'h4444, 15);
    exp_err++;
    expect_word(16'h0123); send_frame(16'h0123, 16);
    send_frame(16'h0555, 0);
    exp_err++;
    expect_word(16'h6789); send_frame(16'h6789, 16);
    tick(2);
    check(err_seen == 3, "R5", "errors at boundaries", 32'(err_seen), 3);
    check(valid_seen == 10, "R5", "frames after aborts", 32'(valid_seen), 10);
    check(word_out == 16'h6789, "R7", "word held in idle", 32'(word_out), 32'h6789);

    // R8: reset mid-frame, then R6 arming again
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 7; i++) send_bit(i[0], 1'b0);
    rst_n = 1'b0;
    tick(3);
    check(word_out == 16'h0, "R8", "word cleared mid-frame", 32'(word_out), 0);
    check(!word_valid && !frame_err, "R8", "strobes low in reset",
          32'({word_valid, frame_err}), 0);
    rst_n = 1'b1;
    send_frame(16'h1357, 16);
    expect_word(16'h2468); send_frame(16'h2468, 16);
    tick(2);
    check(valid_seen == 11 && err_seen == 3, "R6", "arming after mid-frame reset",
          32'(valid_seen), 11);

    tick(20);
    check(exp_q.size() == 0, "R3", "all expected words seen", 32'(exp_q.size()), 0);
    check(exp_err == 0, "R5", "all expected errors seen", 32'(exp_err), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule